// File: doc/BRIEF.md
# Word-Rotating Feedback Stage Buffer

This block is a long linear feedback shift register that sits beside a wide nonlinear state round. It holds 32 stages of eight 32-bit words each, 8192 bits in all. Every iteration moves the contents forward by one stage. The stage that leaves the far end is folded back in at two places. At the head it is XORed with an eight-word block `q_in` supplied by the surrounding logic. Depending on the mode, that block is either an external message block or a slice of the round's state. At stage 25 the same outgoing stage is XORed, word-rotated by two positions, into the contents arriving from stage 24.

The state round reads two fixed stages, 4 and 16, through the tap outputs. All updates share one clock edge. Both the feedback block and the taps refer to contents from before that edge. The surrounding logic raises `adv` on each cycle that performs an iteration. When `adv` is low the buffer holds. A synchronous clear empties the whole buffer.

Top module: `sbuf_core`

## Requirements
- R1: While `rst` is high at a clock edge, every stage becomes zero, so both taps read zero in the following cycle.
- R2: `rst` has priority over `adv`. An edge with both high clears the buffer and takes nothing from `q_in`.
- R3: An edge with `adv` low and `rst` low changes no stage. `q_in` is ignored, and both taps keep their values.
- R4: On an edge with `adv` high, each stage j other than 0 and 25 takes the old contents of stage j-1.
- R5: On an advancing edge, new stage 0 word i equals old stage 31 word i XOR `q_in` word i. Word i of any 256-bit bus occupies bits 32i+31 down to 32i.
- R6: On an advancing edge, new stage 25 word i equals old stage 24 word i XOR old stage 31 word (i+2) mod 8.
- R7: `tap_lo` always shows the registered contents of stage 4 and `tap_hi` those of stage 16. Both change in the cycle after the edge that updates the stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high clear of all stages |
| adv | input | 1 | Perform one iteration at this edge |
| q_in | input | 256 | Feedback block, word i at bits 32i+31:32i |
| tap_lo | output | 256 | Contents of stage 4 |
| tap_hi | output | 256 | Contents of stage 16 |

## Verification
A single set bit is walked through each of the 256 positions of `q_in`. Its arrival at stage 4 after 5 iterations and at stage 16 after 17 iterations is checked against arithmetic expectations. Either check exposes a wrong stage count or a missing head XOR. After 32 iterations the bit leaves stage 31 and re-enters at the head. After 44 iterations `tap_lo` must hold the whole block rotated right by two words. A reversed or off-by-one word rotation at stage 25 lands the bit in the wrong word. A rotation applied to the wrong operand lands it in the wrong stage. Hold cycles driven with non-zero `q_in`, and an edge with both clear and advance high, catch a design that leaks the feedback block or lets the advance win over the clear.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;

    localparam int WORD_W  = 32;
    localparam int WORDS   = 8;
    localparam int STAGE_W = WORD_W * WORDS;

    typedef logic [WORD_W-1:0] word_t;
    typedef word_t [WORDS-1:0] stage_t;

    // word i of the result is word (i+k) mod WORDS of the source
    function automatic stage_t rot_words(stage_t s, int unsigned k);
        stage_t r;
        for (int unsigned i = 0; i < WORDS; i++) begin
            r[i] = s[(i + k) % WORDS];
        end
        return r;
    endfunction

endpackage

// File: rtl/sbuf_fb.sv
module sbuf_fb
    import sbuf_pkg::*;
#(
    parameter int unsigned ROT = 2
) (
    input  stage_t last_st,
    input  stage_t pre_inj_st,
    input  stage_t blk,
    output stage_t head_nxt,
    output stage_t inj_nxt
);
    always_comb begin
        head_nxt = last_st ^ blk;
        inj_nxt  = pre_inj_st ^ rot_words(last_st, ROT);
    end
endmodule

// File: rtl/sbuf_stage.sv
module sbuf_stage
    import sbuf_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   en,
    input  stage_t d,
    output stage_t q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (en) begin
            q <= d;
        end
    end
endmodule

// File: rtl/sbuf_core.sv
module sbuf_core
    import sbuf_pkg::*;
#(
    parameter int NUM_STAGES = 32,
    parameter int INJ_STAGE  = 25,
    parameter int TAP_LO     = 4,
    parameter int TAP_HI     = 16,
    parameter int unsigned ROT = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               adv,
    input  logic [STAGE_W-1:0] q_in,
    output logic [STAGE_W-1:0] tap_lo,
    output logic [STAGE_W-1:0] tap_hi
);
    localparam int LAST = NUM_STAGES - 1;

    stage_t chain [NUM_STAGES];
    stage_t head_nxt;
    stage_t inj_nxt;

    sbuf_fb #(.ROT(ROT)) u_fb (
        .last_st    (chain[LAST]),
        .pre_inj_st (chain[INJ_STAGE-1]),
        .blk        (stage_t'(q_in)),
        .head_nxt   (head_nxt),
        .inj_nxt    (inj_nxt)
    );

    for (genvar j = 0; j < NUM_STAGES; j++) begin : g_st
        stage_t d;
        if (j == 0) begin : g_head
            assign d = head_nxt;
        end else if (j == INJ_STAGE) begin : g_inj
            assign d = inj_nxt;
        end else begin : g_shift
            assign d = chain[j-1];
        end
        sbuf_stage u_st (
            .clk (clk),
            .rst (rst),
            .en  (adv),
            .d   (d),
            .q   (chain[j])
        );
    end

    assign tap_lo = chain[TAP_LO];
    assign tap_hi = chain[TAP_HI];
endmodule

// File: rtl/sbuf_chk.sv
module sbuf_chk
    import sbuf_pkg::*;
#(
    parameter int unsigned ROT = 2
) (
    input logic               clk,
    input logic               rst,
    input logic               adv,
    input logic [STAGE_W-1:0] q_in,
    input logic [STAGE_W-1:0] tap_lo,
    input logic [STAGE_W-1:0] tap_hi,
    input stage_t             st_head,
    input stage_t             st_last,
    input stage_t             st_pre,
    input stage_t             st_inj,
    input stage_t             st_lo_prev,
    input stage_t             st_hi_prev
);
    // R1 R2
    clear_zero_chk: assert property (@(posedge clk)
        rst |=> (tap_lo == '0 && tap_hi == '0));

    // R3
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !adv |=> ($stable(tap_lo) && $stable(tap_hi)));

    // R5
    head_fold_chk: assert property (@(posedge clk) disable iff (rst)
        adv |=> (st_head == $past(st_last ^ stage_t'(q_in))));

    // R6
    inj_rot_chk: assert property (@(posedge clk) disable iff (rst)
        adv |=> (st_inj == $past(st_pre ^ rot_words(st_last, ROT))));

    // R4 R7
    tap_shift_chk: assert property (@(posedge clk) disable iff (rst)
        adv |=> (tap_lo == $past(st_lo_prev) && tap_hi == $past(st_hi_prev)));
endmodule

bind sbuf_core sbuf_chk #(.ROT(ROT)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .adv        (adv),
    .q_in       (q_in),
    .tap_lo     (tap_lo),
    .tap_hi     (tap_hi),
    .st_head    (chain[0]),
    .st_last    (chain[NUM_STAGES-1]),
    .st_pre     (chain[INJ_STAGE-1]),
    .st_inj     (chain[INJ_STAGE]),
    .st_lo_prev (chain[TAP_LO-1]),
    .st_hi_prev (chain[TAP_HI-1])
);

// File: tb/sim_sbuf_core.sv
`timescale 1ns/1ps
module sim_sbuf_core;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         adv = 1'b0;
    logic [255:0] q_in = '0;
    logic [255:0] tap_lo;
    logic [255:0] tap_hi;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] mdl [32][8];

    always #2 clk = ~clk;

    sbuf_core u0 (
        .clk (clk), .rst (rst), .adv (adv),
        .q_in (q_in), .tap_lo (tap_lo), .tap_hi (tap_hi)
    );

    function automatic logic [255:0] mstage(int s);
        logic [255:0] v;
        for (int i = 0; i < 8; i++) v[32*i +: 32] = mdl[s][i];
        return v;
    endfunction

    task automatic model_clear();
        for (int s = 0; s < 32; s++)
            for (int i = 0; i < 8; i++) mdl[s][i] = '0;
    endtask

    task automatic model_adv(input logic [255:0] q);
        logic [31:0] nx [32][8];
        for (int s = 1; s < 32; s++)
            for (int i = 0; i < 8; i++) nx[s][i] = mdl[s-1][i];
        for (int i = 0; i < 8; i++) begin
            nx[0][i]  = mdl[31][i] ^ q[32*i +: 32];
            nx[25][i] = mdl[24][i] ^ mdl[31][(i + 2) % 8];
        end
        mdl = nx;
    endtask

    task automatic check_eq(input string tag, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic a, input logic r, input logic [255:0] q);
        @(negedge clk);
        adv = a; rst = r; q_in = q;
        @(posedge clk);
        #1;
        if (r) model_clear();
        else if (a) model_adv(q);
    endtask

    task automatic check_model(input string tag);
        check_eq({tag, " tap_lo"}, tap_lo, mstage(4));
        check_eq({tag, " tap_hi"}, tap_hi, mstage(16));
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [255:0] x;
        logic [255:0] held_lo;
        logic [255:0] held_hi;
        model_clear();
        step(0, 1, '0);
        step(1, 1, {8{32'hFFFF_FFFF}});
        check_eq("R1 reset tap_lo", tap_lo, '0);
        check_eq("R1 reset tap_hi", tap_hi, '0);

        // R3: q ignored while idle
        step(0, 0, {8{32'hA5A5_5A5A}});
        step(0, 0, {8{32'h1234_5678}});
        check_model("R3 idle from clear");

        // walking single bit through every position of q
        for (int b = 0; b < 256; b++) begin
            x = 256'd1 << b;
            step(0, 1, '0);
            step(1, 0, x);
            for (int n = 2; n <= 49; n++) begin
                step(1, 0, '0);
                if (n == 5)  check_eq("R5 head fold seen at stage 4", tap_lo, x);
                if (n == 17) check_eq("R4 shift to stage 16", tap_hi, x);
                if (n == 37) check_eq("R5 wrap via stage 31", tap_lo, x);
                if (n == 44) check_eq("R6 rotated injection", tap_lo, {x[127:0], x[255:128]} >> 0 == 0 ? '0 : ((x >> 64) | (x << 192)));
                if (n == 49) check_eq("R7 tap_hi after wrap", tap_hi, x);
                if (n % 8 == 0) check_model("R4");
            end
        end

        // R3: hold with data present and busy q
        step(1, 0, {8{32'hDEAD_BEEF}});
        for (int k = 0; k < 6; k++) step(1, 0, {4{64'h0123_4567_89AB_CDEF}});
        held_lo = tap_lo; held_hi = tap_hi;
        for (int k = 0; k < 4; k++) step(0, 0, {8{32'hCAFE_F00D}});
        check_eq("R3 hold tap_lo", tap_lo, held_lo);
        check_eq("R3 hold tap_hi", tap_hi, held_hi);
        check_model("R3 hold model");

        // R2: clear wins over advance
        step(1, 1, {8{32'h7777_7777}});
        check_eq("R2 clear priority tap_lo", tap_lo, '0);
        check_eq("R2 clear priority tap_hi", tap_hi, '0);
        for (int k = 0; k < 4; k++) step(1, 0, '0);
        check_eq("R2 no q captured on clear", tap_lo, '0);

        // mixed stimulus
        for (int k = 0; k < 4000; k++) begin
            logic [255:0] q;
            for (int i = 0; i < 8; i++) q[32*i +: 32] = $urandom;
            step(($urandom % 4) != 0, ($urandom % 97) == 0, q);
            check_model("R7 mixed");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule